// File: doc/BRIEF.md
# Bidirectional Bus Transceiver with Parity

This block links two parallel data buses, side A and side B, through a single set of tri-state drivers whose direction is chosen by a control input. A ninth line carries one parity bit. The block drives that line when it forwards data from A to B, and it reads the line when it forwards data from B to A. A separate status output reports whether the received word and the incoming parity bit agree with the selected parity sense. A single disable input releases every driven line at once. This lets several such bridges share a backplane.

All behaviour is combinational: there is no clock and no storage. Every driver enable is decoded directly from the direction and disable inputs. As a result, no transient internal state can leave both sides of the bridge driving at the same time.

Top module: `bus_xcvr_par`

## Requirements
- R1: With `out_dis` LOW and `dir_tx` HIGH, `b_io` carries the value present on `a_io`.
- R2: With `out_dis` LOW and `dir_tx` LOW, `a_io` carries the value present on `b_io`.
- R3: With `out_dis` HIGH, the block drives none of `a_io`, `b_io`, `par_io` or `err_ok`, whatever the other inputs are.
- R4: In transmit, the block drives `par_io`. With `odd_sel` HIGH the line is HIGH exactly when an even number of `a_io` bits are HIGH. With `odd_sel` LOW the line equals the XOR of all `a_io` bits.
- R5: In receive, `err_ok` is HIGH (word good) exactly when the number of HIGH bits on `b_io` plus `par_io` is odd with `odd_sel` HIGH, or even with `odd_sel` LOW. Otherwise `err_ok` is LOW.
- R6: In transmit, `err_ok` is in high impedance.
- R7: In receive, the block does not drive `par_io`. The value put on it from outside reads back unchanged.
- R8: The block never drives the port that is acting as the source (A in transmit, B in receive). This holds on the very vector that follows a change of direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_io | inout | WIDTH | Side A data bus; driven by the block only in receive |
| b_io | inout | WIDTH | Side B data bus; driven by the block only in transmit |
| par_io | inout | 1 | Parity line; generated output in transmit, check input in receive |
| dir_tx | input | 1 | Direction: HIGH forwards A to B, LOW forwards B to A |
| out_dis | input | 1 | HIGH releases all driven lines to high impedance |
| odd_sel | input | 1 | Parity sense: HIGH selects odd parity across data plus parity bit |
| err_ok | output | 1 | Receive check result, HIGH for good parity; high impedance otherwise |

## Verification
The block holds no state, so a fault can only come from a wrong enable decode or a wrong parity function. Either fault appears at the ports on the same vector that exposes it. A decode fault shows as a port that no longer reads back what the outside world put on it: the source bus in either direction, the parity line in receive, or any line while disabled. It can also show as `err_ok` leaving high impedance in transmit. A parity fault shows as a wrong `par_io` or `err_ok` for that data word. The bench sweeps every data word against both parity senses, both incoming parity values and both directions, and flips the direction on every vector, so each such fault is visible within one sweep step.

// File: rtl/bxp_pkg.sv
package bxp_pkg;

  // Driver enables for every line the block may drive.
  typedef struct packed {
    logic drv_a;
    logic drv_b;
    logic drv_par;
    logic drv_err;
  } drv_en_t;

endpackage

// File: rtl/bxp_dir_decode.sv
module bxp_dir_decode
  import bxp_pkg::*;
(
  input  logic    dir_tx,
  input  logic    out_dis,
  output drv_en_t en
);

  // Enables come straight from the two control inputs: no state, so no
  // overlap of A and B drivers can be produced by a direction change.
  always_comb begin
    en = '0;
    if (!out_dis) begin
      if (dir_tx) begin
        en.drv_b   = 1'b1;
        en.drv_par = 1'b1;
      end else begin
        en.drv_a   = 1'b1;
        en.drv_err = 1'b1;
      end
    end
  end

endmodule

// File: rtl/bxp_parity.sv
module bxp_parity #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] tx_data,
  input  logic [WIDTH-1:0] rx_data,
  input  logic             rx_par,
  input  logic             odd_sel,
  output logic             gen_par,
  output logic             chk_ok
);

  logic tx_xor;
  logic rx_xor;

  assign tx_xor = ^tx_data;
  assign rx_xor = ^rx_data;

  // Generated bit makes data plus parity match the selected sense.
  assign gen_par = tx_xor ^ odd_sel;

  // Good when data plus received bit has the selected sense.
  assign chk_ok  = ~(rx_xor ^ rx_par ^ odd_sel);

endmodule

// File: rtl/bus_xcvr_par.sv
module bus_xcvr_par
  import bxp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  inout  wire  [WIDTH-1:0] a_io,
  inout  wire  [WIDTH-1:0] b_io,
  inout  wire              par_io,
  input  logic             dir_tx,
  input  logic             out_dis,
  input  logic             odd_sel,
  output wire              err_ok
);

  drv_en_t en;
  logic    gen_par;
  logic    chk_ok;

  bxp_dir_decode u_dec (
    .dir_tx  (dir_tx),
    .out_dis (out_dis),
    .en      (en)
  );

  bxp_parity #(.WIDTH(WIDTH)) u_par (
    .tx_data (a_io),
    .rx_data (b_io),
    .rx_par  (par_io),
    .odd_sel (odd_sel),
    .gen_par (gen_par),
    .chk_ok  (chk_ok)
  );

  assign b_io   = en.drv_b   ? a_io    : {WIDTH{1'bz}};
  assign a_io   = en.drv_a   ? b_io    : {WIDTH{1'bz}};
  assign par_io = en.drv_par ? gen_par : 1'bz;
  assign err_ok = en.drv_err ? chk_ok  : 1'bz;

  // Driver-enable relations between the decoder and the output stages.
  always_comb begin
    if (!$isunknown({dir_tx, out_dis})) begin
      p_single_side_r8: assert (!(en.drv_a && en.drv_b))
        else $error("A and B drivers enabled together");
      p_release_all_r3: assert (!out_dis || (en == '0))
        else $error("driver enabled while disabled");
      p_err_in_rx_r6: assert (!en.drv_err || (en.drv_a && !dir_tx))
        else $error("status driven outside receive");
      p_par_in_tx_r7: assert (en.drv_par == en.drv_b)
        else $error("parity driver not tied to transmit");
    end
  end

endmodule

// File: tb/bus_xcvr_par_test.sv
module bus_xcvr_par_test;

  localparam int W = 8;
  localparam int MAX_CYC = 200000;

  logic clk;
  logic rst_n;
  logic [W-1:0] tb_a, tb_b;
  logic tb_a_on, tb_b_on, tb_p, tb_p_on;
  logic dir_tx, out_dis, odd_sel;
  wire  [W-1:0] a_bus, b_bus;
  wire  par_w, err_w;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  assign a_bus = tb_a_on ? tb_a : {W{1'bz}};
  assign b_bus = tb_b_on ? tb_b : {W{1'bz}};
  assign par_w = tb_p_on ? tb_p : 1'bz;

  bus_xcvr_par #(.WIDTH(W)) uut (
    .a_io    (a_bus),
    .b_io    (b_bus),
    .par_io  (par_w),
    .dir_tx  (dir_tx),
    .out_dis (out_dis),
    .odd_sel (odd_sel),
    .err_ok  (err_w)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= MAX_CYC && !done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected<%0d", cyc, MAX_CYC);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string rq, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b", rq, act, exp);
    end
  endtask

  function automatic int ones(input logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) if (v[i]) n++;
    return n;
  endfunction

  // Behavioural reference: compare all ports at the falling edge.
  task automatic compare();
    int n;
    logic exp_par, exp_ok;
    @(negedge clk);
    if (out_dis) begin
      chk("R3 a", a_bus, tb_a);
      chk("R3 b", b_bus, tb_b);
      chk("R3 par", {{W-1{1'b0}}, par_w}, {{W-1{1'b0}}, tb_p});
      chk("R3 err", {{W-1{1'b0}}, err_w}, {{W-1{1'b0}}, 1'bz});
    end else if (dir_tx) begin
      n = ones(tb_a);
      exp_par = odd_sel ? (n % 2 == 0) : (n % 2 == 1);
      chk("R1", b_bus, tb_a);
      chk("R8 a", a_bus, tb_a);
      chk("R4", {{W-1{1'b0}}, par_w}, {{W-1{1'b0}}, exp_par});
      chk("R6", {{W-1{1'b0}}, err_w}, {{W-1{1'b0}}, 1'bz});
    end else begin
      n = ones(tb_b) + (tb_p ? 1 : 0);
      exp_ok = odd_sel ? (n % 2 == 1) : (n % 2 == 0);
      chk("R2", a_bus, tb_b);
      chk("R8 b", b_bus, tb_b);
      chk("R7", {{W-1{1'b0}}, par_w}, {{W-1{1'b0}}, tb_p});
      chk("R5", {{W-1{1'b0}}, err_w}, {{W-1{1'b0}}, exp_ok});
    end
  endtask

  // Bench drives only the lines the block should leave alone.
  task automatic apply(input logic d, input logic dis, input logic s,
                       input logic p, input logic [W-1:0] va, input logic [W-1:0] vb);
    @(posedge clk);
    #1;
    dir_tx  = d;
    out_dis = dis;
    odd_sel = s;
    tb_a = va;
    tb_b = vb;
    tb_p = p;
    tb_a_on = dis | d;
    tb_b_on = dis | ~d;
    tb_p_on = dis | ~d;
    compare();
  endtask

  initial begin
    rst_n = 1'b0;
    dir_tx = 1'b0; out_dis = 1'b1; odd_sel = 1'b0;
    tb_a = 8'h3c; tb_b = 8'hc3; tb_p = 1'b1;
    tb_a_on = 1'b1; tb_b_on = 1'b1; tb_p_on = 1'b1;
    repeat (3) @(posedge clk);
    // Reset state: everything released (R3).
    compare();
    #1 rst_n = 1'b1;
    for (int v = 0; v < 256; v++) begin
      for (int s = 0; s < 2; s++) begin
        for (int p = 0; p < 2; p++) begin
          // Direction alternates each vector to exercise flips (R8).
          apply(1'b1, 1'b0, s[0], p[0], v[W-1:0], ~v[W-1:0]);
          apply(1'b0, 1'b0, s[0], p[0], ~v[W-1:0], v[W-1:0]);
        end
      end
      if (v % 16 == 0) begin
        apply(1'b1, 1'b1, v[0], v[1], v[W-1:0], ~v[W-1:0]);
        apply(1'b0, 1'b1, v[1], v[0], ~v[W-1:0], v[W-1:0]);
      end
    end
    // Boundary words, both senses (R4, R5).
    apply(1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h55);
    apply(1'b1, 1'b0, 1'b1, 1'b0, 8'hff, 8'h55);
    apply(1'b0, 1'b0, 1'b0, 1'b1, 8'haa, 8'h01);
    apply(1'b0, 1'b0, 1'b1, 1'b1, 8'haa, 8'hff);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule